// File: doc/BRIEF.md
# Dual-Bank Interrupt Request Controller

This block collects up to 32 interrupt lines and presents them to a processor as two independent request outputs: a normal request and a fast request. Each output is served by its own register bank. Both banks see the same input lines, but each has its own per-line configuration. Software uses a bank to decide which lines reach that output and how each line is detected.

Every line is first passed through a two-flop synchroniser. In each bank a line is either level-detected or edge-detected, and it has a polarity bit. Edge events are held in a latch until software acknowledges them by writing ones to the bank's clear word. The pending bits of a bank are gated by its enable mask to form a masked status word. The bank's request output is high whenever any status bit is set.

Access is through a simple word bus: address, write enable, write data and a combinational read data path. Writes take effect at the clock edge on which the write enable is high.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, the mask, mode and polarity registers and all edge latches of both banks are zero, both status words read zero, and both request outputs are low.
- R2: Each bank has a read/write mask register (normal bank at byte offset 0x04). A 1 in a bit enables that line and a 0 blocks it. The mask changes only when it is written.
- R3: A line whose mode bit is 0 is level-detected. Its source bit (offset 0x00) equals the input when its polarity bit is 0, and the inverted input when its polarity bit is 1. It follows an input change after two clock edges. The mode register is at offset 0x0C and the polarity register at 0x10.
- R4: A line whose mode bit is 1 is edge-detected. Polarity 0 selects the rising edge and 1 selects the falling edge, and the other edge is ignored. The source bit is set on the third clock edge after the input changes and stays set after the input returns.
- R5: Writing a word to the clear register (offset 0x08) clears the edge latch of each line whose bit is 1. Lines whose bit is 0 are unchanged. Clear writes have no effect on level-detected lines, and the clear offset reads as zero.
- R6: If a selected edge is detected on the same clock edge as a clear write to that line, the latch stays set.
- R7: The status register (offset 0x14) reads source AND mask. The bank's request output is the OR of its status bits.
- R8: The fast bank repeats the six registers at offsets 0x20 to 0x34, with the same layout. Its mask, mode, polarity, latches and output are independent of the normal bank.
- R9: Offsets 0x18, 0x1C, 0x38 and 0x3C read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | N_LINES | Interrupt lines, may be asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address; bit 5 selects the bank, bits 4:2 select the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
A wrong edge latch shows up on the source and status reads, and on the request output, on the cycle after the edge or clear that should have changed it. Lost or stuck latches are caught by checks made both before and after the third clock edge following an input change. A corrupted mask or polarity bit changes the status word and the request pin as soon as the register is written. Cross-bank leakage appears as a wrong read from the other bank's unchanged registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef logic [2:0] reg_idx_t;
  localparam reg_idx_t REG_SRC  = 3'd0;
  localparam reg_idx_t REG_MASK = 3'd1;
  localparam reg_idx_t REG_CLR  = 3'd2;
  localparam reg_idx_t REG_MODE = 3'd3;
  localparam reg_idx_t REG_LVL  = 3'd4;
  localparam reg_idx_t REG_STAT = 3'd5;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_idx_t     idx_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] prev_i,
  output logic [N-1:0] rdata_o,
  output logic         req_o
);
  logic [N-1:0] mask_q, mode_q, lvl_q, lat_q, lat_d;
  logic [N-1:0] rise, fall, edge_hit, clr_vec, src, stat;

  assign rise     = sync_i & ~prev_i;
  assign fall     = ~sync_i & prev_i;
  assign edge_hit = mode_q & ((lvl_q & fall) | (~lvl_q & rise));
  assign clr_vec  = (wr_i && idx_i == REG_CLR) ? wdata_i : '0;
  // a fresh edge wins over a coincident clear
  assign lat_d    = ((lat_q & ~clr_vec) | edge_hit) & mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= '0;
      lvl_q  <= '0;
      lat_q  <= '0;
    end else begin
      lat_q <= lat_d;
      if (wr_i) begin
        case (idx_i)
          REG_MASK: mask_q <= wdata_i;
          REG_MODE: mode_q <= wdata_i;
          REG_LVL:  lvl_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign src   = (mode_q & lat_q) | (~mode_q & (sync_i ^ lvl_q));
  assign stat  = src & mask_q;
  assign req_o = |stat;

  always_comb begin
    case (idx_i)
      REG_SRC:  rdata_o = src;
      REG_MASK: rdata_o = mask_q;
      REG_MODE: rdata_o = mode_q;
      REG_LVL:  rdata_o = lvl_q;
      REG_STAT: rdata_o = stat;
      default:  rdata_o = '0;
    endcase
  end

  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_hit && !(wr_i && idx_i == REG_MODE)) |=> ((src & $past(edge_hit)) == $past(edge_hit)))
    else $error("edge not latched"); // R4

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == REG_CLR) |=> ((lat_q & $past(wdata_i & ~edge_hit)) == '0))
    else $error("latch survived clear"); // R5

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == REG_MASK) |=> $stable(mask_q))
    else $error("mask changed without write"); // R2

  AST_REQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !req_o)
    else $error("request with empty mask"); // R7
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned N_BANKS  = 2;
  localparam int unsigned BANK_BIT = 5;

  logic [N_LINES-1:0] sync_s, prev_s;
  logic [N_LINES-1:0] bank_rd [N_BANKS];
  logic [N_BANKS-1:0] bank_req;
  reg_idx_t           idx;
  logic               bank_sel;
  logic               unused_addr;

  assign idx         = addr_i[4:2];
  assign bank_sel    = addr_i[BANK_BIT];
  assign unused_addr = ^addr_i[1:0];

  irqc_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(lines_i),
    .sync_o (sync_s),
    .prev_o (prev_s)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    irqc_bank #(.N(N_LINES)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i && (bank_sel == 1'(b))),
      .idx_i  (idx),
      .wdata_i(wdata_i[N_LINES-1:0]),
      .sync_i (sync_s),
      .prev_i (prev_s),
      .rdata_o(bank_rd[b]),
      .req_o  (bank_req[b])
    );
  end

  if (N_LINES < DATA_W) begin : g_pad
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:N_LINES];
    assign rdata_o = {{(DATA_W-N_LINES){1'b0}}, bank_rd[bank_sel]};
  end else begin : g_full
    assign rdata_o = bank_rd[bank_sel];
  end

  assign irq_o = bank_req[0];
  assign fiq_o = bank_req[1];
endmodule

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb;
  typedef struct {
    int          kind;  // 0 read, 1 irq pin, 2 fiq pin
    logic [5:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lines = '0;
  logic        wr_en = 0;
  logic [5:0]  drv_addr = '0, mon_addr = '0, addr;
  logic        mon_act = 0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;
  item_t       q[$];
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;
  assign addr = mon_act ? mon_addr : drv_addr;

  irq_fiq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      wait (q.size() > 0);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        mon_act  = 1;
        mon_addr = it.addr;
        #1;
        act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, fiq};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d addr=%h act=%h exp=%h", it.tag, it.kind, it.addr, act, it.exp);
        end
        mon_act = 0;
      end
    end
  end

  task automatic push(int kind, logic [5:0] a, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic exp_rd(logic [5:0] a, logic [31:0] e, string tag);
    push(0, a, e, tag);
    flush();
  endtask

  task automatic exp_pins(logic i, logic f, string tag);
    push(1, 6'h00, {31'b0, i}, tag);
    push(2, 6'h00, {31'b0, f}, tag);
    flush();
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    drv_addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    exp_rd(6'h04, 32'h0, "R1 irq mask");
    exp_rd(6'h24, 32'h0, "R1 fiq mask");
    exp_rd(6'h14, 32'h0, "R1 irq status");
    exp_rd(6'h34, 32'h0, "R1 fiq status");
    exp_pins(0, 0, "R1 pins");

    // R3 level active-high, masked out then enabled
    lines[0] = 1;
    tick(1);
    exp_rd(6'h00, 32'h0, "R3 before two edges");
    exp_rd(6'h00, 32'h1, "R3 level high");
    exp_pins(0, 0, "R7 masked line");
    wr(6'h04, 32'h1);
    exp_rd(6'h04, 32'h1, "R2 mask readback");
    exp_rd(6'h14, 32'h1, "R7 status");
    exp_pins(1, 0, "R7 irq raised");

    // R3 active-low polarity
    wr(6'h10, 32'h2);
    exp_rd(6'h00, 32'h3, "R3 active low idle");
    lines[1] = 1;
    tick(2);
    exp_rd(6'h00, 32'h1, "R3 active low driven");

    // R5 clear has no effect on level lines
    wr(6'h08, 32'h3);
    exp_rd(6'h00, 32'h1, "R5 level ignores clear");
    exp_rd(6'h08, 32'h0, "R5 clear reads zero");

    // R4 rising edge
    wr(6'h0C, 32'h10);
    exp_rd(6'h0C, 32'h10, "R3 mode readback");
    lines[4] = 1;
    tick(2);
    exp_rd(6'h00, 32'h01, "R4 not yet latched");
    exp_rd(6'h00, 32'h11, "R4 rising latched");
    lines[4] = 0;
    tick(3);
    exp_rd(6'h00, 32'h11, "R4 sticky");
    wr(6'h08, 32'h20);
    exp_rd(6'h00, 32'h11, "R5 zero bit leaves latch");
    wr(6'h08, 32'h10);
    exp_rd(6'h00, 32'h01, "R5 clear drops latch");

    // R4 falling edge
    wr(6'h0C, 32'h30);
    wr(6'h10, 32'h22);
    lines[5] = 1;
    tick(3);
    exp_rd(6'h00, 32'h01, "R4 rising ignored on falling line");
    lines[5] = 0;
    tick(3);
    exp_rd(6'h00, 32'h21, "R4 falling latched");

    // R6 edge coincides with clear
    lines[4] = 1;
    tick(2);
    wr(6'h08, 32'h10);
    exp_rd(6'h00, 32'h31, "R6 edge wins over clear");
    wr(6'h08, 32'h10);
    exp_rd(6'h00, 32'h21, "R6 later clear works");

    // R7 status and request
    exp_rd(6'h14, 32'h01, "R7 status mask 1");
    wr(6'h04, 32'h20);
    exp_rd(6'h14, 32'h20, "R7 status mask 20");
    exp_pins(1, 0, "R7 irq from edge");
    wr(6'h08, 32'h20);
    exp_rd(6'h14, 32'h0, "R7 status after clear");
    exp_pins(0, 0, "R7 irq dropped");

    // R8 fast bank independent; lines 0,1,4 high
    exp_rd(6'h20, 32'h13, "R8 fiq source");
    wr(6'h24, 32'h2);
    exp_rd(6'h34, 32'h2, "R8 fiq status");
    exp_pins(0, 1, "R8 fiq raised");
    exp_rd(6'h04, 32'h20, "R8 irq mask untouched");
    exp_rd(6'h0C, 32'h30, "R8 irq mode untouched");
    wr(6'h30, 32'h2);
    exp_rd(6'h34, 32'h0, "R8 fiq polarity");
    exp_pins(0, 0, "R8 fiq dropped");

    // R9 unused offsets
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    exp_rd(6'h18, 32'h0, "R9 read 0x18");
    exp_rd(6'h3C, 32'h0, "R9 read 0x3C");
    exp_rd(6'h04, 32'h20, "R9 irq mask kept");
    exp_rd(6'h24, 32'h2, "R9 fiq mask kept");
    exp_pins(0, 0, "R9 pins kept");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule